// File: doc/BRIEF.md
# 4x4 Inverse Transform Reconstruct Unit

This unit rebuilds one 4x4 block of 8-bit pixels from a block of signed 16-bit residual coefficients and a 4x4 block of prediction pixels. A per-block nonzero count travels with the block. Together with the DC coefficient, it selects one of three paths:

- **Skip:** the prediction is passed through unchanged.
- **DC-only:** one rounded offset is added to all sixteen pixels.
- **Full:** a two-pass integer inverse transform runs, and its residual is added pixel by pixel.

Every addition saturates to the unsigned 8-bit range.

A block is loaded in parallel through a valid/ready port. The unit holds it while it computes the result, then streams four rows of four pixels out through a second valid/ready port, top row first. The load port stays closed until the last row of the current block has been taken. Only one block is ever in flight.

Top module: `idct4_recon`

## Requirements
- R1: When the nonzero count is 0, every output pixel equals its prediction pixel, whatever the coefficients hold.
- R2: When the nonzero count is 1 and coefficient 0 (bits 15:0 of the coefficient bus) is nonzero, every pixel becomes its prediction plus (coefficient0 + 32) >> 6 (arithmetic shift), and the other fifteen coefficients have no effect.
- R3: When the nonzero count is 1 and coefficient 0 is zero, the block goes through the full transform of R4.
- R4: For any count of 2 or more, and for the case of R3, the full transform runs in this order:
  - Each row of four coefficients (coefficient r*4+c sits at bits 16*(r*4+c)) goes through the butterfly e0=x0+x2, e1=x0-x2, e2=(x1>>1)-x3, e3=x1+(x3>>1), giving y0=e0+e3, y1=e1+e2, y2=e1-e2, y3=e0-e3.
  - 32 is added to the element at row 0, column 0.
  - Each column goes through the same butterfly.
  - Each result is shifted right arithmetically by 6 and added to the prediction pixel at the same position.
- R5: All intermediate values of the transform are 16-bit two's complement and wrap on overflow.
- R6: Every pixel sum saturates to 0 below zero and to 255 above 255, on both the DC-only and the full path.
- R7: The rows leave top to bottom. The row index (0..3) comes with each row, and the last flag is set only with row 3. The first row becomes valid two cycles after the accepting edge.
- R8: While the output is valid and not taken, the row data and row index stay unchanged.
- R9: The load port is not ready from the acceptance of a block until the handshake of its row 3. It is ready again in the cycle that follows, and a block offered meanwhile is neither taken nor allowed to disturb the block in flight.
- R10: After reset the output is not valid and the load port is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A block is offered on the load port |
| in_ready | output | 1 | The unit can take a block |
| in_coef | input | 256 | Sixteen signed 16-bit coefficients, coefficient r*4+c at bits 16*(r*4+c) |
| in_pred | input | 128 | Sixteen prediction pixels, pixel r*4+c at bits 8*(r*4+c) |
| in_nnz | input | NNZ_W (8) | Nonzero count of the block |
| out_valid | output | 1 | A reconstructed row is presented |
| out_ready | input | 1 | The consumer takes the row |
| out_row | output | 32 | Four pixels of the row, column c at bits 8*c |
| out_row_idx | output | 2 | Row number of the presented row |
| out_last | output | 1 | The presented row is row 3 |

## Verification
Two events can land on the same cycle. One is the handshake that completes a block's last row. The other is a new block already being offered on the load port. The bench raises the valid of the next block as soon as the current one is accepted and holds it through the whole output stream, while random back-pressure stalls rows at arbitrary points.

The checks cover four things:
- The load port stays closed through the entire stream, including the last-row cycle.
- The waiting block is taken only on the cycle after that handshake.
- Every pixel of both the old and the new block matches a bench model built from the requirements.
- Stalled rows hold still.

// File: rtl/idct4_pkg.sv
package idct4_pkg;

    localparam int COEF_W = 16;
    localparam int PIX_W  = 8;
    localparam int BLK_N  = 4;
    localparam int BLK_SZ = BLK_N * BLK_N;
    localparam int SHIFT  = 6;
    localparam int ROUND  = 1 << (SHIFT - 1);
    localparam int SUM_W  = PIX_W + 4;
    localparam int ROW_BITS  = BLK_N * PIX_W;
    localparam int COEF_BITS = BLK_SZ * COEF_W;
    localparam int PIX_BITS  = BLK_SZ * PIX_W;
    localparam int IDX_W     = $clog2(BLK_N);

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic [BLK_N-1:0][COEF_W-1:0] quad_t;

    typedef enum logic [1:0] {
        PATH_SKIP = 2'd0,
        PATH_DC   = 2'd1,
        PATH_FULL = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_SEND = 2'd2
    } state_e;

    typedef struct packed {
        path_e path;
        sum_t  dc_off;
    } sel_t;

    // Four-point integer butterfly, all values wrap at 16 bits.
    function automatic quad_t butterfly(input coef_t x0, input coef_t x1,
                                        input coef_t x2, input coef_t x3);
        coef_t even_s, even_d, odd_a, odd_b;
        quad_t q;
        even_s = x0 + x2;
        even_d = x0 - x2;
        odd_a  = (x1 >>> 1) - x3;
        odd_b  = x1 + (x3 >>> 1);
        q[0] = even_s + odd_b;
        q[1] = even_d + odd_a;
        q[2] = even_d - odd_a;
        q[3] = even_s - odd_b;
        return q;
    endfunction

    // Clamp a signed sum into the unsigned pixel range.
    function automatic pix_t clip_pix(input sum_t s);
        pix_t r;
        if (s[SUM_W-1])
            r = '0;
        else if (|s[SUM_W-2:PIX_W])
            r = '1;
        else
            r = s[PIX_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/idct4_path_sel.sv
module idct4_path_sel
    import idct4_pkg::*;
#(
    parameter int NNZ_W = 8
) (
    input  logic [NNZ_W-1:0] nnz_i,
    input  coef_t            dc_i,
    output sel_t             sel_o
);

    logic signed [COEF_W:0] dc_rnd;
    logic signed [COEF_W:0] dc_shf;

    always_comb begin
        dc_rnd = {dc_i[COEF_W-1], dc_i} + $signed((COEF_W + 1)'(ROUND));
        dc_shf = dc_rnd >>> SHIFT;
        sel_o.dc_off = SUM_W'(dc_shf);
        if (nnz_i == '0)
            sel_o.path = PATH_SKIP;
        else if ((nnz_i == NNZ_W'(1)) && (dc_i != '0))
            sel_o.path = PATH_DC;
        else
            sel_o.path = PATH_FULL;
    end

endmodule

// File: rtl/idct4_xform.sv
module idct4_xform
    import idct4_pkg::*;
(
    input  logic [COEF_BITS-1:0] coef_i,
    output logic [COEF_BITS-1:0] resid_o
);

    coef_t src  [BLK_SZ];
    coef_t hpas [BLK_SZ];
    coef_t vin  [BLK_SZ];

    genvar g, r, c, k;

    for (g = 0; g < BLK_SZ; g++) begin : g_unpack
        assign src[g] = coef_t'(coef_i[g*COEF_W +: COEF_W]);
    end

    // First pass: each row.
    for (r = 0; r < BLK_N; r++) begin : g_rows
        quad_t rq;
        assign rq = butterfly(src[r*BLK_N], src[r*BLK_N+1],
                              src[r*BLK_N+2], src[r*BLK_N+3]);
        for (k = 0; k < BLK_N; k++) begin : g_rk
            assign hpas[r*BLK_N+k] = coef_t'(rq[k]);
        end
    end

    // Rounding bias on the corner term only.
    for (g = 0; g < BLK_SZ; g++) begin : g_bias
        if (g == 0) begin : g_corner
            assign vin[g] = hpas[g] + coef_t'(ROUND);
        end else begin : g_plain
            assign vin[g] = hpas[g];
        end
    end

    // Second pass: each column, then scale down.
    for (c = 0; c < BLK_N; c++) begin : g_cols
        quad_t cq;
        assign cq = butterfly(vin[c], vin[BLK_N+c], vin[2*BLK_N+c], vin[3*BLK_N+c]);
        for (k = 0; k < BLK_N; k++) begin : g_ck
            coef_t v;
            assign v = coef_t'(cq[k]);
            assign resid_o[(k*BLK_N+c)*COEF_W +: COEF_W] = v >>> SHIFT;
        end
    end

endmodule

// File: rtl/idct4_recon_add.sv
module idct4_recon_add
    import idct4_pkg::*;
(
    input  sel_t                 sel_i,
    input  logic [PIX_BITS-1:0]  pred_i,
    input  logic [COEF_BITS-1:0] resid_i,
    output logic [PIX_BITS-1:0]  pix_o
);

    genvar g;
    for (g = 0; g < BLK_SZ; g++) begin : g_pix
        coef_t rv;
        sum_t  off;
        sum_t  sum;
        assign rv = coef_t'(resid_i[g*COEF_W +: COEF_W]);
        always_comb begin
            case (sel_i.path)
                PATH_DC:   off = sel_i.dc_off;
                PATH_FULL: off = SUM_W'(rv);
                default:   off = '0;
            endcase
            sum = $signed({{(SUM_W-PIX_W){1'b0}}, pred_i[g*PIX_W +: PIX_W]}) + off;
        end
        assign pix_o[g*PIX_W +: PIX_W] = clip_pix(sum);
    end

endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
    import idct4_pkg::*;
#(
    parameter int NNZ_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [COEF_BITS-1:0] in_coef,
    input  logic [PIX_BITS-1:0]  in_pred,
    input  logic [NNZ_W-1:0]     in_nnz,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ROW_BITS-1:0]  out_row,
    output logic [IDX_W-1:0]     out_row_idx,
    output logic                 out_last
);

    state_e                st_q;
    logic [COEF_BITS-1:0]  coef_q;
    logic [PIX_BITS-1:0]   pred_q;
    logic [PIX_BITS-1:0]   pix_q;
    logic [PIX_BITS-1:0]   pix_d;
    logic [COEF_BITS-1:0]  resid;
    logic [IDX_W-1:0]      row_q;
    sel_t                  sel_d;
    sel_t                  sel_q;
    logic                  accept;
    logic                  fire;
    logic [ROW_BITS-1:0]   rows [BLK_N];

    idct4_path_sel #(.NNZ_W(NNZ_W)) u_sel (
        .nnz_i (in_nnz),
        .dc_i  (coef_t'(in_coef[COEF_W-1:0])),
        .sel_o (sel_d)
    );

    idct4_xform u_xf (
        .coef_i  (coef_q),
        .resid_o (resid)
    );

    idct4_recon_add u_add (
        .sel_i   (sel_q),
        .pred_i  (pred_q),
        .resid_i (resid),
        .pix_o   (pix_d)
    );

    genvar k;
    for (k = 0; k < BLK_N; k++) begin : g_rowmux
        assign rows[k] = pix_q[k*ROW_BITS +: ROW_BITS];
    end

    assign in_ready    = (st_q == ST_IDLE);
    assign out_valid   = (st_q == ST_SEND);
    assign accept      = in_valid && in_ready;
    assign fire        = out_valid && out_ready;
    assign out_row     = rows[row_q];
    assign out_row_idx = row_q;
    assign out_last    = (row_q == IDX_W'(BLK_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            row_q  <= '0;
            coef_q <= '0;
            pred_q <= '0;
            pix_q  <= '0;
            sel_q  <= '{path: PATH_SKIP, dc_off: '0};
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        coef_q <= in_coef;
                        pred_q <= in_pred;
                        sel_q  <= sel_d;
                        st_q   <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    pix_q <= pix_d;
                    row_q <= '0;
                    st_q  <= ST_SEND;
                end
                ST_SEND: begin
                    if (fire) begin
                        if (out_last)
                            st_q <= ST_IDLE;
                        else
                            row_q <= row_q + IDX_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/idct4_recon_chk.sv
module idct4_recon_chk
    import idct4_pkg::*;
#(
    parameter int NNZ_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [ROW_BITS-1:0] in_pred_row0,
    input logic [NNZ_W-1:0]    in_nnz,
    input logic                out_valid,
    input logic                out_ready,
    input logic [ROW_BITS-1:0] out_row,
    input logic [IDX_W-1:0]    out_row_idx,
    input logic                out_last
);

    AST_BUSY_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R9

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_row_idx))); // R8

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (out_valid && (out_row_idx == $past(out_row_idx) + 2'd1))); // R7

    AST_LAST_REOPENS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready)); // R9

    AST_FIRST_ROW_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !out_valid ##1 (out_valid && (out_row_idx == '0))); // R7

    AST_SKIP_PASSES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (in_nnz == '0)) |=> ##1 (out_row == $past(in_pred_row0, 2))); // R1

endmodule

bind idct4_recon idct4_recon_chk #(.NNZ_W(NNZ_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_pred_row0 (in_pred[idct4_pkg::ROW_BITS-1:0]),
    .in_nnz       (in_nnz),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_row      (out_row),
    .out_row_idx  (out_row_idx),
    .out_last     (out_last)
);

// File: tb/test_idct4_recon.sv
`timescale 1ns/1ps
module test_idct4_recon;

    localparam int NBLK = 160;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_coef = '0;
    logic [127:0] in_pred = '0;
    logic [7:0]   in_nnz = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_row;
    logic [1:0]   out_row_idx;
    logic         out_last;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    idct4_recon i_idct4_recon (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .in_pred(in_pred), .in_nnz(in_nnz),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .out_row_idx(out_row_idx), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic bfly(input shortint a, input shortint b, input shortint c, input shortint d,
                        output shortint y0, output shortint y1, output shortint y2, output shortint y3);
        shortint p, q, r, s;
        p = a + c;
        q = a - c;
        r = (b >>> 1) - d;
        s = b + (d >>> 1);
        y0 = p + s;
        y1 = q + r;
        y2 = q - r;
        y3 = p - s;
    endtask

    function automatic logic [7:0] sat8(input int v);
        if (v < 0) return 8'd0;
        if (v > 255) return 8'd255;
        return 8'(v);
    endfunction

    // Reference built from the requirements (R1..R6).
    task automatic model(input logic [255:0] cf, input logic [127:0] pd, input logic [7:0] nz,
                         output logic [31:0] rows_e [4]);
        shortint a [16];
        shortint t [16];
        shortint o [16];
        logic [7:0] px [16];
        shortint dc;
        int off;
        for (int i = 0; i < 16; i++) a[i] = shortint'(cf[i*16 +: 16]);
        dc = a[0];
        if (nz == 8'd0) begin
            for (int i = 0; i < 16; i++) px[i] = pd[i*8 +: 8];
        end else if (nz == 8'd1 && dc != 0) begin
            off = (int'(dc) + 32) >>> 6;
            for (int i = 0; i < 16; i++) px[i] = sat8(int'(pd[i*8 +: 8]) + off);
        end else begin
            for (int r = 0; r < 4; r++)
                bfly(a[r*4], a[r*4+1], a[r*4+2], a[r*4+3], t[r*4], t[r*4+1], t[r*4+2], t[r*4+3]);
            t[0] = t[0] + 16'sd32;
            for (int c = 0; c < 4; c++)
                bfly(t[c], t[4+c], t[8+c], t[12+c], o[c], o[4+c], o[8+c], o[12+c]);
            for (int i = 0; i < 16; i++) px[i] = sat8(int'(pd[i*8 +: 8]) + (int'(o[i]) >>> 6));
        end
        for (int r = 0; r < 4; r++)
            rows_e[r] = {px[r*4+3], px[r*4+2], px[r*4+1], px[r*4]};
    endtask

    function automatic logic [15:0] small_coef();
        return 16'(int'($urandom_range(600)) - 300);
    endfunction

    task automatic gen_block(input int k, output logic [255:0] cf, output logic [127:0] pd,
                             output logic [7:0] nz, output string tag);
        int sel;
        for (int i = 0; i < 16; i++) cf[i*16 +: 16] = small_coef();
        for (int i = 0; i < 16; i++) pd[i*8 +: 8] = 8'($urandom);
        case (k)
            0: begin nz = 8'd0; tag = "R1"; end
            1: begin cf[15:0] = 16'sd1000; pd = {16{8'd250}}; nz = 8'd1; tag = "R2"; end
            2: begin cf[15:0] = -16'sd2000; pd = {16{8'd10}}; nz = 8'd1; tag = "R6"; end
            3: begin cf[15:0] = 16'd0; nz = 8'd1; tag = "R3"; end
            4: begin cf = {16{16'h7fff}}; nz = 8'd16; tag = "R5"; end
            5: begin cf[15:0] = -16'sd32; nz = 8'd1; tag = "R2"; end
            6: begin cf[15:0] = 16'h7fff; nz = 8'd1; tag = "R6"; end
            7: begin
                for (int i = 0; i < 16; i++) cf[i*16 +: 16] = (i % 2 == 0) ? 16'sd9000 : -16'sd7000;
                for (int i = 0; i < 16; i++) pd[i*8 +: 8] = (i % 3 == 0) ? 8'd0 : 8'd255;
                nz = 8'd9; tag = "R6";
            end
            8: begin cf = {16{16'h8000}}; nz = 8'd3; tag = "R5"; end
            default: begin
                if ($urandom_range(3) == 0)
                    for (int i = 0; i < 16; i++) cf[i*16 +: 16] = 16'($urandom);
                if ($urandom_range(4) == 0) cf[15:0] = 16'd0;
                sel = int'($urandom_range(3));
                if (sel == 0) nz = 8'd0;
                else if (sel == 1) nz = 8'd1;
                else nz = 8'($urandom_range(16, 2));
                if (nz == 8'd0) tag = "R1";
                else if (nz == 8'd1 && cf[15:0] != 16'd0) tag = "R2";
                else if (nz == 8'd1) tag = "R3";
                else tag = "R4";
            end
        endcase
    endtask

    // Drain the four rows of one block under random back-pressure.
    task automatic collect(input logic [31:0] rows_e [4], input string tag);
        int r = 0;
        bit held = 1'b0;
        logic [31:0] held_row = '0;
        logic [1:0]  held_idx = '0;
        bit rdy;
        while (r < 4) begin
            chk(in_ready == 1'b0, "R9", "load port open while block in flight", 32'(in_ready), 32'd0);
            if (out_valid && held) begin
                chk(out_row == held_row, "R8", "stalled row changed", out_row, held_row);
                chk(out_row_idx == held_idx, "R8", "stalled index changed", 32'(out_row_idx), 32'(held_idx));
            end
            rdy = ($urandom_range(9) >= 3);
            held = 1'b0;
            if (out_valid && rdy) begin
                chk(out_row == rows_e[r], tag, $sformatf("row %0d pixels", r), out_row, rows_e[r]);
                chk(out_row_idx == 2'(r), "R7", "row index", 32'(out_row_idx), 32'(r));
                chk(out_last == (r == 3), "R7", "last flag", 32'(out_last), 32'(r == 3));
                r++;
            end else if (out_valid) begin
                held = 1'b1;
                held_row = out_row;
                held_idx = out_row_idx;
            end
            out_ready = rdy;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R7", "valid after last row", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R9", "load port reopens after last row", 32'(in_ready), 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [255:0] cur_c, nxt_c;
        logic [127:0] cur_p, nxt_p;
        logic [7:0]   cur_n, nxt_n;
        string        cur_t, nxt_t;
        logic [31:0]  rows_e [4];
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R10", "valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R10", "ready after reset", 32'(in_ready), 32'd1);
        repeat (2) @(negedge clk);

        gen_block(0, cur_c, cur_p, cur_n, cur_t);
        in_coef = cur_c; in_pred = cur_p; in_nnz = cur_n; in_valid = 1'b1;
        for (int b = 0; b < NBLK; b++) begin
            model(cur_c, cur_p, cur_n, rows_e);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            // The next block is offered at once while this one streams (R9).
            if (b < NBLK - 1) begin
                gen_block(b + 1, nxt_c, nxt_p, nxt_n, nxt_t);
                in_coef = nxt_c; in_pred = nxt_p; in_nnz = nxt_n; in_valid = 1'b1;
            end else begin
                nxt_c = '0; nxt_p = '0; nxt_n = '0; nxt_t = "R4";
                in_valid = 1'b0;
            end
            collect(rows_e, cur_t);
            cur_c = nxt_c; cur_p = nxt_p; cur_n = nxt_n; cur_t = nxt_t;
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule